// File: doc/BRIEF.md
# Staged Clock-Enable Divider Bank

This block produces fourteen independent clock-enable pulse streams for a video output subsystem. There are two channels, primary and secondary. Each channel has seven dividers, one for each interface domain: analog monitor, picture path, TV encoder, HDMI pixel-pair, HDMI, output interface and layer. Each divider is set by a 3-bit field. A field value N makes its enable output go high for one cycle out of every N+1 input clock cycles.

Software programs the fields through a simple address/data write port that covers two registers. The selection register holds the monitor and picture fields of both channels. The parameter register holds the other ten fields and an update flag. Field writes land in a staging copy. The running dividers do not see them until the flag is written from 0 to 1. At that point every staged field is committed in the same cycle. Each divider then switches to its new value at its own next terminal count, so no enable period is ever cut short.

The commit control is a three-state machine:
- UPD_OPEN: the flag is low and writes are staged.
- UPD_COMMIT: one cycle in which the staged fields are handed to all dividers.
- UPD_HELD: the flag is high; writes are staged but not applied.

The transitions are:
- OPEN to COMMIT when a parameter write sets the flag.
- COMMIT to HELD on any cycle without a flag-clearing write.
- COMMIT to OPEN, or HELD to OPEN, when a parameter write clears the flag.

Top module: `clkdiv_bank`

## Requirements
- R1: The enable output `div_en` has 14 bits. Bit index = channel*7 + kind, where channel 0 is primary and channel 1 is secondary. The kind order is: 0 monitor, 1 picture, 2 TV encoder, 3 HDMI pixel-pair, 4 HDMI, 5 interface, 6 layer.
- R2: Address 0 is the selection register. The field for channel c and kind k (k < 2) sits at bits [c*6+k*3 +: 3]. A write to it changes no kind 2..6 field.
- R3: Address 1 is the parameter register. The field for channel c and kind k (k >= 2) sits at bits [c*15+(k-2)*3 +: 3]. Bit 30 is the update flag.
- R4: After reset every field and the flag are 0, so every enable output is high on every cycle from the first clock edge after reset.
- R5: A committed field value N makes that enable output high for exactly one cycle out of every N+1 cycles.
- R6: While the flag is 0, field writes are staged and leave the running enable periods unchanged.
- R7: A parameter write that moves the flag from 0 to 1 commits all staged fields of both registers together, including the fields carried by that same write.
- R8: Field writes made while the flag is already 1, including a write that sets the flag again, are staged but not applied until the next 0-to-1 transition.
- R9: A divider adopts a newly committed value only at its next terminal count. Every interval between enable pulses therefore equals either the old period or the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that all dividers count |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 1 | 0 selects the selection register, 1 the parameter register |
| wr_data | input | 31 | Write data: field bits and, at address 1, the update flag in bit 30 |
| div_en | output | 14 | One clock-enable pulse stream per divider |

## Verification
The hardest case to provoke is a commit that arrives while the dividers are midway through long periods. In that case the old value must finish its count before the new one starts. The bench first settles all dividers at the slowest setting. It then commits the fastest-but-one setting and records every pulse interval from the commit cycle onward, accepting only the old or the new period. A second difficult case is the set-again write while the flag is already 1. The bench reaches it by setting the flag, rewriting fields with the flag still set, and confirming that the measured periods stay unchanged until the flag is cleared and set once more.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int DIV_FW        = 3;
    localparam int DIV_KINDS     = 7;
    localparam int DIV_SEL_KINDS = 2;
    localparam int DIV_CHANS     = 2;

    typedef enum logic [1:0] {
        UPD_OPEN   = 2'd0,
        UPD_COMMIT = 2'd1,
        UPD_HELD   = 2'd2
    } upd_state_t;

    // Which register (0 selection, 1 parameter) carries a kind.
    function automatic int field_reg(input int k, input int sel_kinds);
        return (k < sel_kinds) ? 0 : 1;
    endfunction

    // Low bit of the field for channel ch, kind k inside its register.
    function automatic int field_lsb(input int ch, input int k,
                                     input int sel_kinds, input int kinds,
                                     input int fw);
        if (k < sel_kinds)
            return ch * sel_kinds * fw + k * fw;
        return ch * (kinds - sel_kinds) * fw + (k - sel_kinds) * fw;
    endfunction

endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
    import clkdiv_pkg::*;
#(
    parameter int FW        = DIV_FW,
    parameter int KINDS     = DIV_KINDS,
    parameter int SEL_KINDS = DIV_SEL_KINDS,
    parameter int CHANS     = DIV_CHANS,
    parameter int REG_W     = CHANS * (KINDS - SEL_KINDS) * FW + 1,
    parameter int N_DIV     = CHANS * KINDS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    output logic                  commit_o,
    output logic [N_DIV*FW-1:0]   staged_o
);

    localparam int FLAG_BIT = REG_W - 1;

    upd_state_t state_q, state_d;
    logic       par_wr, flag_set_wr, flag_clr_wr;

    assign par_wr      = wr_en && wr_addr;
    assign flag_set_wr = par_wr &&  wr_data[FLAG_BIT];
    assign flag_clr_wr = par_wr && !wr_data[FLAG_BIT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= UPD_OPEN;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_OPEN:   if (flag_set_wr) state_d = UPD_COMMIT;
            UPD_COMMIT: state_d = flag_clr_wr ? UPD_OPEN : UPD_HELD;
            UPD_HELD:   if (flag_clr_wr) state_d = UPD_OPEN;
            default:    state_d = UPD_OPEN;
        endcase
    end

    // Output logic
    always_comb begin
        commit_o = (state_q == UPD_COMMIT);
    end

    // Staging copy of every field
    for (genvar ch = 0; ch < CHANS; ch++) begin : g_ch
        for (genvar k = 0; k < KINDS; k++) begin : g_kind
            localparam int IDX = ch * KINDS + k;
            localparam int REG = field_reg(k, SEL_KINDS);
            localparam int LSB = field_lsb(ch, k, SEL_KINDS, KINDS, FW);
            logic [FW-1:0] stg_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg_q <= '0;
                else if (wr_en && (wr_addr == 1'(REG)))
                    stg_q <= wr_data[LSB +: FW];
            end
            assign staged_o[IDX*FW +: FW] = stg_q;
        end
    end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_i,
    input  logic [FW-1:0] value_i,
    output logic          en_o
);

    logic [FW-1:0] pend_q, act_q, cnt_q;
    logic          en_q;
    logic          terminal;

    assign terminal = (cnt_q == act_q);

    // Committed value, held until the divider reaches terminal count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= '0;
        else if (commit_i)
            pend_q <= value_i;
    end

    // Counting state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (terminal) begin
            cnt_q <= '0;
            act_q <= pend_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered enable pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= terminal;
    end

    assign en_o = en_q;

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int FW        = DIV_FW,
    parameter int KINDS     = DIV_KINDS,
    parameter int SEL_KINDS = DIV_SEL_KINDS,
    parameter int CHANS     = DIV_CHANS,
    parameter int REG_W     = CHANS * (KINDS - SEL_KINDS) * FW + 1,
    parameter int N_DIV     = CHANS * KINDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [N_DIV-1:0] div_en
);

    logic                commit_w;
    logic [N_DIV*FW-1:0] staged_w;

    clkdiv_stage #(
        .FW(FW), .KINDS(KINDS), .SEL_KINDS(SEL_KINDS),
        .CHANS(CHANS), .REG_W(REG_W), .N_DIV(N_DIV)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit_o (commit_w),
        .staged_o (staged_w)
    );

    for (genvar d = 0; d < N_DIV; d++) begin : g_div
        clkdiv_counter #(.FW(FW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .commit_i (commit_w),
            .value_i  (staged_w[d*FW +: FW]),
            .en_o     (div_en[d])
        );
    end

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
    parameter int FW    = 3,
    parameter int REG_W = 31,
    parameter int N_DIV = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [REG_W-1:0] wr_data,
    input logic [N_DIV-1:0] div_en,
    input logic             commit
);

    localparam int MAX_GAP = (1 << FW) - 1;

    // A commit lasts exactly one cycle (R7)
    p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // A commit is always caused by a flag-setting parameter write (R7, R8)
    p_commit_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(wr_en && wr_addr && wr_data[REG_W-1]));

    // Clearing the flag never produces a commit on the next cycle (R6)
    p_clear_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && !wr_data[REG_W-1]) |=> !commit);

    // Gap between pulses never exceeds the slowest period (R5, R9)
    for (genvar d = 0; d < N_DIV; d++) begin : g_gap
        logic [FW:0] gap_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gap_q <= '0;
            else if (div_en[d])
                gap_q <= '0;
            else if (gap_q != {(FW+1){1'b1}})
                gap_q <= gap_q + 1'b1;
        end
        p_gap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
            gap_q <= (FW+1)'(MAX_GAP));
    end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(.FW(FW), .REG_W(REG_W), .N_DIV(N_DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .div_en  (div_en),
    .commit  (commit_w)
);

// File: tb/sim_clkdiv_bank.sv
module sim_clkdiv_bank;

    localparam int N = 14;
    localparam int RW = 31;
    localparam int FLAG = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [RW-1:0] wr_data = '0;
    logic [N-1:0]  div_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int exp_old [N];
    int exp_new [N];
    int vals [N];

    always #4 clk = ~clk;

    clkdiv_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .div_en(div_en)
    );

    // R2: selection register layout
    function automatic logic [RW-1:0] pack_sel(input int v [N]);
        logic [RW-1:0] r = '0;
        for (int d = 0; d < N; d++) begin
            int ch = d / 7;
            int k = d % 7;
            if (k < 2) r[ch*6 + k*3 +: 3] = 3'(v[d]);
        end
        return r;
    endfunction

    // R3: parameter register layout
    function automatic logic [RW-1:0] pack_par(input int v [N], input bit flag);
        logic [RW-1:0] r = '0;
        for (int d = 0; d < N; d++) begin
            int ch = d / 7;
            int k = d % 7;
            if (k >= 2) r[ch*15 + (k-2)*3 +: 3] = 3'(v[d]);
        end
        r[FLAG] = flag;
        return r;
    endfunction

    task automatic wr(input logic a, input logic [RW-1:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_exp(input int o [N], input int nw [N]);
        for (int d = 0; d < N; d++) begin
            exp_old[d] = o[d] + 1;
            exp_new[d] = nw[d] + 1;
        end
    endtask

    // Records pulse intervals; each must equal old or new period, the last must be the new one.
    task automatic measure(input int win, input string tag);
        int last_t [N];
        int pulses [N];
        int bad [N];
        int last_iv [N];
        for (int d = 0; d < N; d++) begin
            last_t[d] = 0; pulses[d] = 0; bad[d] = 0; last_iv[d] = 0;
        end
        for (int t = 0; t < win; t++) begin
            @(negedge clk);
            for (int d = 0; d < N; d++) begin
                if (div_en[d]) begin
                    if (pulses[d] > 0) begin
                        int iv = t - last_t[d];
                        if (iv != exp_old[d] && iv != exp_new[d]) bad[d]++;
                        last_iv[d] = iv;
                    end
                    pulses[d]++;
                    last_t[d] = t;
                end
            end
        end
        for (int d = 0; d < N; d++) begin
            checks++;
            if (bad[d] != 0 || pulses[d] < 3 || last_iv[d] != exp_new[d]) begin
                errors++;
                $display("FAIL %s div%0d: actual period=%0d bad=%0d pulses=%0d expected period=%0d (old %0d)",
                         tag, d, last_iv[d], bad[d], pulses[d], exp_new[d], exp_old[d]);
            end
        end
    endtask

    task automatic program_all(input int v [N]);
        wr(1'b1, pack_par(v, 1'b0));
        wr(1'b0, pack_sel(v));
        wr(1'b1, pack_par(v, 1'b1));
    endtask

    initial begin
        int prev [N];
        int nxt [N];
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: after reset every output high on every cycle
        checks++;
        if (div_en !== {N{1'b1}}) begin
            errors++;
            $display("FAIL R4 reset: actual div_en=%h expected=%h", div_en, {N{1'b1}});
        end
        for (int d = 0; d < N; d++) vals[d] = 0;
        set_exp(vals, vals);
        measure(12, "R4 reset divide-by-one");

        // R1 R2 R3 R5 R7: sweep every value through every divider
        for (int s = 0; s < 8; s++) begin
            prev = vals;
            for (int d = 0; d < N; d++) vals[d] = (d + s) % 8;
            program_all(vals);
            idle(20);
            set_exp(vals, vals);
            measure(40, $sformatf("R1 R2 R3 R5 R7 sweep%0d", s));
        end

        // R6: staged writes with flag low do not reach dividers
        prev = vals;
        for (int d = 0; d < N; d++) nxt[d] = 2;
        wr(1'b1, pack_par(nxt, 1'b0));
        wr(1'b0, pack_sel(nxt));
        idle(20);
        set_exp(prev, prev);
        measure(40, "R6 staged while flag low");
        wr(1'b1, pack_par(nxt, 1'b1));
        idle(20);
        set_exp(nxt, nxt);
        measure(40, "R7 commit after staging");

        // R8: writes while flag already high are not applied
        prev = nxt;
        for (int d = 0; d < N; d++) nxt[d] = 5;
        wr(1'b0, pack_sel(nxt));
        wr(1'b1, pack_par(nxt, 1'b1));
        idle(20);
        set_exp(prev, prev);
        measure(40, "R8 set-again not applied");
        wr(1'b1, pack_par(nxt, 1'b0));
        wr(1'b1, pack_par(nxt, 1'b1));
        idle(20);
        set_exp(nxt, nxt);
        measure(40, "R8 applied on next rise");

        // R2: selection-only change leaves parameter fields intact
        prev = nxt;
        for (int d = 0; d < N; d++) nxt[d] = ((d % 7) < 2) ? 1 : prev[d];
        wr(1'b1, pack_par(prev, 1'b0));
        wr(1'b0, pack_sel(nxt));
        wr(1'b1, pack_par(prev, 1'b1));
        idle(20);
        set_exp(nxt, nxt);
        measure(40, "R2 selection-only write");

        // R9: commit mid-count, slow to fast
        for (int d = 0; d < N; d++) prev[d] = 7;
        program_all(prev);
        idle(20);
        for (int d = 0; d < N; d++) nxt[d] = 1;
        idle(3);
        wr(1'b1, pack_par(prev, 1'b0));
        wr(1'b0, pack_sel(nxt));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = pack_par(nxt, 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        set_exp(prev, nxt);
        measure(40, "R9 switch at terminal count");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule